// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block moves the system clock from a slow secondary oscillator to the main oscillator when software sets a source-select bit. The main oscillator may be a crystal, a crystal feeding a PLL, or an RC or external clock. Each needs a different settling time, so the block first runs a wait sequence chosen by a two-bit mode code. The wait counters run on the main-oscillator clock. During the wait the system keeps running on the secondary clock, so the instruction stream keeps advancing.

When the wait finishes, a glitch-free gate hands the output over to the new source. The secondary clock is held low once it has completed a full four-phase instruction cycle. The new source is then enabled on its own falling edge. A ready flag tells software that the new clock is in charge.

If the select bit is cleared before the wait ends, the sequence aborts and the counters reset. Clearing the bit after the switch returns the system to the secondary clock through the same handoff.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset, the system clock output follows the secondary clock and ready is low.
- R2: With mode code 2'b00 (crystal), the main clock drives the output only after OST_CYCLES main-clock cycles have been counted following the synchronised request.
- R3: With mode code 2'b01 (crystal with PLL), the OST_CYCLES count is followed by a further PLL_LOCK_CYCLES main-clock cycles, and the PLL clock then drives the output.
- R4: With mode codes 2'b10 and 2'b11 (RC or external clock, with or without I/O), there is no start-up count, and the main clock takes over after SHORT_CYCLES main-clock cycles.
- R5: While the wait is in progress, the output keeps running at the secondary clock rate.
- R6: The secondary clock is cut off only at the end of the fourth phase of an instruction cycle. Counting from reset, the number of secondary high pulses passed to the output before the handoff is a multiple of four.
- R7: The output never shows a runt pulse. The two gate enables are never on together, and each source is enabled or disabled only while it is low.
- R8: Ready stays low during the wait. It rises on the first rising edge the new source places on the output.
- R9: Clearing the select bit during the wait resets the counters and keeps the secondary clock selected, with ready low. A later request waits the full count again.
- R10: Clearing the select bit after a switch returns the output to the secondary clock and drops ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sec_clk_i | input | 1 | Secondary (low-frequency) oscillator clock |
| main_clk_i | input | 1 | Main oscillator clock; clocks the wait counters |
| pll_clk_i | input | 1 | PLL output clock, used in mode 2'b01 |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Oscillator mode code (00 crystal, 01 crystal+PLL, 10 RC, 11 external) |
| sel_main_i | input | 1 | Source select: 1 requests the main source, 0 the secondary |
| sys_clk_o | output | 1 | Gated system clock |
| ready_o | output | 1 | High while the new source drives the system clock |

## Verification
A wait counter with the wrong terminal value or the wrong branch for a mode shows up at the ports as a ready rise too early or too late. This is caught by timing, in main-clock cycles, the gap between the request and the rise of ready. Each mode's window is narrow enough to tell it apart from the others. A gate enable left in a wrong state shows up within a few system-clock edges: the output period differs from the expected source, a pulse is shorter than either source's half period, the Q-phase alignment is off, or more than one new-source edge appears before ready. A timer that does not clear on abort makes the follow-up request finish well below its lower bound.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  typedef enum logic [1:0] {
    MODE_XTAL     = 2'b00,
    MODE_XTAL_PLL = 2'b01,
    MODE_RC       = 2'b10,
    MODE_EXT      = 2'b11
  } osc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OST,
    ST_LOCK,
    ST_SHORT,
    ST_DONE
  } wait_st_e;

  function automatic logic skips_ost(osc_mode_e m);
    return (m == MODE_RC) || (m == MODE_EXT);
  endfunction

endpackage

// File: rtl/clksw_sync2.sv
`timescale 1ns/1ps
module clksw_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/clksw_wait_timer.sv
`timescale 1ns/1ps
module clksw_wait_timer
  import clksw_pkg::*;
#(
  parameter int unsigned OST_CYCLES      = 1024,
  parameter int unsigned PLL_LOCK_CYCLES = 8000,
  parameter int unsigned SHORT_CYCLES    = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  osc_mode_e mode_i,
  output logic      done_o,
  output logic      use_pll_o
);

  localparam int unsigned MAX_A = (OST_CYCLES > PLL_LOCK_CYCLES) ? OST_CYCLES : PLL_LOCK_CYCLES;
  localparam int unsigned MAX_C = (MAX_A > SHORT_CYCLES) ? MAX_A : SHORT_CYCLES;
  localparam int unsigned CW    = $clog2(MAX_C + 1);
  localparam int unsigned CKW   = CW + 2;

  wait_st_e        st_q;
  osc_mode_e       mode_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= MODE_XTAL;
    end else if (!req_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          mode_q <= mode_i;
          cnt_q  <= '0;
          st_q   <= skips_ost(mode_i) ? ST_SHORT : ST_OST;
        end
        ST_OST: begin
          if (cnt_q == CW'(OST_CYCLES - 1)) begin
            cnt_q <= '0;
            st_q  <= (mode_q == MODE_XTAL_PLL) ? ST_LOCK : ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (cnt_q == CW'(PLL_LOCK_CYCLES - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHORT: begin
          if (cnt_q == CW'(SHORT_CYCLES - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  assign done_o    = (st_q == ST_DONE);
  assign use_pll_o = (mode_q == MODE_XTAL_PLL);

  // independent cycle count since request, for the wait-length check
  logic [CKW-1:0] chk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              chk_q <= '0;
    else if (!req_i)          chk_q <= '0;
    else if (st_q != ST_DONE) chk_q <= chk_q + 1'b1;
  end

  logic [CKW-1:0] exp_len;
  always_comb begin
    if (skips_ost(mode_q))            exp_len = CKW'(SHORT_CYCLES + 1);
    else if (mode_q == MODE_XTAL_PLL) exp_len = CKW'(OST_CYCLES + PLL_LOCK_CYCLES + 1);
    else                              exp_len = CKW'(OST_CYCLES + 1);
  end

  // R2, R3 and R4: total wait matches the mode
  a_r2_wait_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> chk_q == exp_len);

  a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);

endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
module clksw_gate #(
  parameter int unsigned PHASES = 4
) (
  input  logic sec_clk_i,
  input  logic tgt_clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic sys_clk_o,
  output logic ready_o
);

  localparam int unsigned QW = $clog2(PHASES);
  localparam logic [QW-1:0] Q_LAST = QW'(PHASES - 1);

  logic [QW-1:0] q_cnt;
  logic sec_en, new_en;
  logic done_s, new_off_s;
  logic done_t, sec_off_t;

  // phase index of the current secondary pulse; first pulse after reset is phase 0
  always_ff @(posedge sec_clk_i or negedge rst_ni) begin
    if (!rst_ni) q_cnt <= Q_LAST;
    else         q_cnt <= q_cnt + 1'b1;
  end

  clksw_sync2 #(.RST_VAL(1'b0)) u_done_s (
    .clk_i(sec_clk_i), .rst_ni(rst_ni), .d_i(done_i), .q_o(done_s));
  clksw_sync2 #(.RST_VAL(1'b1)) u_newoff_s (
    .clk_i(sec_clk_i), .rst_ni(rst_ni), .d_i(~new_en), .q_o(new_off_s));

  always_ff @(negedge sec_clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  sec_en <= 1'b1;
    else if (sec_en && done_s && q_cnt == Q_LAST) sec_en <= 1'b0;
    else if (!sec_en && !done_s && new_off_s)     sec_en <= 1'b1;
  end

  clksw_sync2 #(.RST_VAL(1'b0)) u_done_t (
    .clk_i(tgt_clk_i), .rst_ni(rst_ni), .d_i(done_i), .q_o(done_t));
  clksw_sync2 #(.RST_VAL(1'b0)) u_secoff_t (
    .clk_i(tgt_clk_i), .rst_ni(rst_ni), .d_i(~sec_en), .q_o(sec_off_t));

  always_ff @(negedge tgt_clk_i or negedge rst_ni) begin
    if (!rst_ni) new_en <= 1'b0;
    else         new_en <= done_t && sec_off_t;
  end

  always_ff @(posedge tgt_clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_o <= 1'b0;
    else         ready_o <= new_en;
  end

  assign sys_clk_o = (sec_clk_i & sec_en) | (tgt_clk_i & new_en);

  always_comb begin
    if (rst_ni) begin
      a_r7_exclusive: assert (!(sec_en && new_en));
      a_r8_ready_excl: assert (!(ready_o && sec_en));
    end
  end

  a_r6_q_boundary: assert property (@(negedge sec_clk_i) disable iff (!rst_ni)
    $fell(sec_en) |-> q_cnt == '0);

endmodule

// File: rtl/clk_switch_seq.sv
`timescale 1ns/1ps
module clk_switch_seq
  import clksw_pkg::*;
#(
  parameter int unsigned OSC_HZ          = 4_000_000,
  parameter int unsigned OST_CYCLES      = 1024,
  parameter int unsigned PLL_LOCK_CYCLES = OSC_HZ / 500,
  parameter int unsigned SHORT_CYCLES    = 8,
  parameter int unsigned PHASES          = 4
) (
  input  logic       sec_clk_i,
  input  logic       main_clk_i,
  input  logic       pll_clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sel_main_i,
  output logic       sys_clk_o,
  output logic       ready_o
);

  logic req_s, done, use_pll, tgt_clk;

  clksw_sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk_i(main_clk_i), .rst_ni(rst_ni), .d_i(sel_main_i), .q_o(req_s));

  clksw_wait_timer #(
    .OST_CYCLES     (OST_CYCLES),
    .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES),
    .SHORT_CYCLES   (SHORT_CYCLES)
  ) u_timer (
    .clk_i    (main_clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_s),
    .mode_i   (osc_mode_e'(mode_i)),
    .done_o   (done),
    .use_pll_o(use_pll)
  );

  // select is only updated while the new branch is idle
  assign tgt_clk = use_pll ? pll_clk_i : main_clk_i;

  clksw_gate #(.PHASES(PHASES)) u_gate (
    .sec_clk_i(sec_clk_i),
    .tgt_clk_i(tgt_clk),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .sys_clk_o(sys_clk_o),
    .ready_o  (ready_o)
  );

endmodule

// File: tb/clk_switch_seq_bench.sv
`timescale 1ns/1ps
module clk_switch_seq_bench;

  localparam int OST   = 64;
  localparam int LOCK  = 96;
  localparam int SHORT = 8;
  localparam int SLACK = 40;

  logic sec_clk = 1'b0, main_clk = 1'b0, pll_clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sel = 1'b0;
  logic sys_clk, ready;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;

  always #5  main_clk = ~main_clk;   // 100 MHz
  always #13 sec_clk  = ~sec_clk;
  always #4  pll_clk  = ~pll_clk;

  clk_switch_seq #(
    .OST_CYCLES(OST), .PLL_LOCK_CYCLES(LOCK), .SHORT_CYCLES(SHORT)
  ) u_clk_switch_seq (
    .sec_clk_i(sec_clk), .main_clk_i(main_clk), .pll_clk_i(pll_clk),
    .rst_ni(rst_ni), .mode_i(mode), .sel_main_i(sel),
    .sys_clk_o(sys_clk), .ready_o(ready)
  );

  // output pulse monitor
  realtime rise_t = 0, fall_t = 0;
  bit started = 0;
  int runts = 0, sec_pulses = 0, new_edges = 0;
  int edges_at_ready = -1, pulses_at_ready = -1;

  always @(posedge sys_clk) begin
    if (started && fall_t > 0 && ($realtime - fall_t) < 3.5) runts++;
    rise_t = $realtime;
    new_edges++;
  end

  always @(negedge sys_clk) begin
    if (started && rise_t > 0) begin
      if (($realtime - rise_t) < 3.5) runts++;
      if (($realtime - rise_t) > 12.0) begin
        sec_pulses++;
        new_edges = 0;
      end
    end
    fall_t = $realtime;
  end

  always @(posedge ready) begin
    #0.1;
    edges_at_ready  = new_edges;
    pulses_at_ready = sec_pulses;
  end

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic tick();
    @(negedge main_clk);
    #1;
  endtask

  task automatic period(output realtime p);
    realtime t0;
    @(posedge sys_clk);
    @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    p = $realtime - t0;
    tick();
  endtask

  task automatic check_period(input realtime exp, input string tag);
    realtime p;
    period(p);
    check(p > exp - 0.5 && p < exp + 0.5, tag,
          $sformatf("period act=%0.1f exp=%0.1f", p, exp));
  endtask

  task automatic t_reset();
    check(ready === 1'b0, "R1", $sformatf("ready act=%b exp=0", ready));
    check_period(26.0, "R1");
  endtask

  task automatic t_abort();
    bit seen = 0;
    mode = 2'b00;
    sel  = 1'b1;
    repeat (30) tick();
    check(ready === 1'b0, "R5", $sformatf("ready during wait act=%b exp=0", ready));
    check_period(26.0, "R5");
    sel = 1'b0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (ready) seen = 1;
    end
    check(!seen, "R9", $sformatf("ready after abort act=%b exp=0", seen));
    check_period(26.0, "R9");
  endtask

  task automatic t_switch(input logic [1:0] m, input int lo, input int hi,
                          input realtime exp_p, input string tag);
    int n = 0;
    mode = m;
    sel  = 1'b1;
    while (!ready && n < 400) begin
      tick();
      n++;
    end
    check(n >= lo && n <= hi, tag,
          $sformatf("mode %b wait act=%0d exp=%0d..%0d", m, n, lo, hi));
    check(edges_at_ready == 1, "R8",
          $sformatf("new edges at ready act=%0d exp=1", edges_at_ready));
    check_period(exp_p, tag);
  endtask

  task automatic t_back();
    int n = 0;
    sel = 1'b0;
    while (ready && n < 100) begin
      tick();
      n++;
    end
    check(ready === 1'b0, "R10", $sformatf("ready after deselect act=%b exp=0", ready));
    check_period(26.0, "R10");
  endtask

  initial begin
    #30 rst_ni = 1'b1;
    started = 1;
    tick();
    t_reset();
    t_abort();
    // R9: full count again after abort
    t_switch(2'b00, OST + 3, OST + SLACK, 10.0, "R2");
    check(pulses_at_ready > 0 && pulses_at_ready % 4 == 0, "R6",
          $sformatf("secondary pulses before handoff act=%0d exp=multiple of 4", pulses_at_ready));
    t_back();
    t_switch(2'b01, OST + LOCK + 3, OST + LOCK + SLACK, 8.0, "R3");
    t_back();
    t_switch(2'b10, SHORT + 3, SHORT + SLACK, 10.0, "R4");
    t_back();
    t_switch(2'b11, SHORT + 3, SHORT + SLACK, 10.0, "R4");
    t_back();
    check(runts == 0, "R7", $sformatf("runt pulses act=%0d exp=0", runts));
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      done_flag = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule